// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and steers each one to one of eight processor interrupt lines. Software programs a per-source enable bit and a per-source 4-bit line selector through a small register bus. An output line is asserted while at least one enabled, asserted source is steered to it. Sources need no acknowledge: a line falls once every source that drives it has gone low or been disabled.

For software dispatch, the block also offers a read-only view of the pending set, meaning the enable bits ANDed with the raw source levels. It also presents the index of the lowest-numbered pending source on dedicated outputs. A handler reads that index, services the device, and the source drops out of the pending set once the device releases its request. Priority between lines, vectoring and edge capture are not part of the block.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00000000, every steering register reads 0x00000000, and all eight output lines are low.
- R2: The enable register sits at byte offset 0x00. A full 32-bit write stores the value and a read returns the last value written. Bit s enables source s, and a source whose bit is 0 never drives a line.
- R3: The four steering registers sit at offsets 0x08, 0x0C, 0x10 and 0x14. Each is written as a full 32-bit word and read back unchanged. The selector for source s is bits [(s mod 8)*4+3 : (s mod 8)*4] of the register at offset 0x08 + 4*(s div 8).
- R4: Offset 0x04 reads the raw source levels in the same cycle (bit s = input s), and offset 0x18 reads the enable register ANDed with the raw levels. Writes to either offset change no register.
- R5: Output line L is high in the cycle after a clock edge exactly when, at that edge, some source s had its enable bit set, its input high and a selector equal to L. The output is registered, so it responds one clock after its inputs change.
- R6: A selector value from 8 to 15 steers its source to no line, whatever the source's level and enable.
- R7: pend_valid_o is high exactly when the pending set is non-empty. pend_idx_o then gives the lowest-numbered pending source. Both follow the inputs and registers within the same cycle.
- R8: Sources are level-sensitive with no acknowledge. A line stays high for as long as an enabled source steered to it stays high, and it falls one clock after the last such source goes low.
- R9: Offsets not listed above read 0x00000000, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_level_i | input | 32 | Level of each interrupt source, active high |
| bus_wr_en_i | input | 1 | Write strobe for the register bus |
| bus_addr_i | input | 8 | Byte offset of the accessed register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_line_o | output | 8 | Processor interrupt lines, registered, active high |
| pend_valid_o | output | 1 | At least one source is pending |
| pend_idx_o | output | 5 | Lowest-numbered pending source |

## Verification
A corrupted selector or enable bit shows up on the output lines at the first clock edge where the affected source is high. It also shows up at once in the readback of its register and in the pending view at offset 0x18. The bench walks single sources across all 32 positions and steers them to every line, so any misplaced field bit puts the wrong line high one clock later. A broken lowest-index search shows in the same cycle on pend_idx_o. The bench compares that output, together with all eight lines, against its model on every clock.

// File: rtl/routed_irq_pkg.sv
package routed_irq_pkg;

  // Byte offsets of the register map
  localparam int OFS_MASK       = 'h00;
  localparam int OFS_STAT       = 'h04;
  localparam int OFS_ROUTE_BASE = 'h08;
  localparam int WORD_BYTES     = 4;

  // Offset of steering register k; the pending view follows the last one
  function automatic int route_offset(input int k);
    return OFS_ROUTE_BASE + WORD_BYTES * k;
  endfunction

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import routed_irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 4,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NUM_SRC-1:0]          src_i,
  output logic [NUM_SRC-1:0]          mask_o,
  output logic [NUM_SRC*FIELD_W-1:0]  route_flat_o,
  output logic [DATA_W-1:0]           rdata_o
);

  localparam int NUM_ROUTE_REGS = (NUM_SRC * FIELD_W) / DATA_W;
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(route_offset(NUM_ROUTE_REGS));

  // Enable register
  logic               mask_en;
  logic [NUM_SRC-1:0] mask_d;
  logic [NUM_SRC-1:0] mask_q;

  assign mask_en = wr_en_i && (addr_i == A_MASK);

  always_comb begin
    mask_d = wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  // a_r2_mask_hold: the enable register only changes on a write to its offset
  a_r2_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (addr_i == A_MASK)) |=> $stable(mask_q))
    else $error("R2 enable register changed without a write");

  // Steering registers
  logic [DATA_W-1:0] route_q [NUM_ROUTE_REGS];

  for (genvar k = 0; k < NUM_ROUTE_REGS; k++) begin : g_route
    localparam logic [ADDR_W-1:0] A_ROUTE = ADDR_W'(route_offset(k));
    logic              route_en;
    logic [DATA_W-1:0] route_d;

    assign route_en = wr_en_i && (addr_i == A_ROUTE);

    always_comb begin
      route_d = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[k] <= '0;
      end else if (route_en) begin
        route_q[k] <= route_d;
      end
    end

    assign route_flat_o[k*DATA_W +: DATA_W] = route_q[k];

    a_r3_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && (addr_i == A_ROUTE)) |=> $stable(route_q[k]))
      else $error("R3 steering register changed without a write");

    a_r3_route_load: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (addr_i == A_ROUTE)) |=> (route_q[k] == $past(wdata_i)))
      else $error("R3 steering register did not take the written word");
  end

  // Read multiplexer
  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASK) rdata_o = DATA_W'(mask_q);
    if (addr_i == A_STAT) rdata_o = DATA_W'(src_i);
    if (addr_i == A_PEND) rdata_o = DATA_W'(mask_q & src_i);
    for (int k = 0; k < NUM_ROUTE_REGS; k++) begin
      if (addr_i == ADDR_W'(route_offset(k))) rdata_o = route_q[k];
    end
  end

endmodule

// File: rtl/irq_line_router.sv
module irq_line_router #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_LINES = 8,
  parameter int FIELD_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          mask_i,
  input  logic [NUM_SRC-1:0]          src_i,
  input  logic [NUM_SRC*FIELD_W-1:0]  route_flat_i,
  output logic [NUM_LINES-1:0]        line_o
);

  logic [NUM_SRC-1:0]                  active;
  logic [NUM_LINES-1:0][NUM_SRC-1:0]   sel;
  logic [NUM_LINES-1:0]                line_d;
  logic [NUM_LINES-1:0]                line_q;

  assign active = mask_i & src_i;

  // Selector values at or above NUM_LINES match no line
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign sel[l][s] = (route_flat_i[s*FIELD_W +: FIELD_W] == FIELD_W'(l));
    end
    assign line_d[l] = |(active & sel[l]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
    end else begin
      line_q <= line_d;
    end
  end

  assign line_o = line_q;

  // a_r2_masked_silent: with every source disabled no line rises
  a_r2_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |=> (line_o == '0))
    else $error("R2 line high with all sources disabled");

  // a_r8_idle_silent: with every source low all lines fall next cycle
  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (src_i == '0) |=> (line_o == '0))
    else $error("R8 line high with all sources low");

endmodule

// File: rtl/irq_lowest_finder.sv
module irq_lowest_finder #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0] pend_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);

  always_comb begin
    valid_o = |pend_i;
    idx_o   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_LINES = 8,
  parameter int FIELD_W   = 4,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_SRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_level_i,
  input  logic                 bus_wr_en_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_line_o,
  output logic                 pend_valid_o,
  output logic [IDX_W-1:0]     pend_idx_o
);

  logic [NUM_SRC-1:0]         mask;
  logic [NUM_SRC*FIELD_W-1:0] route_flat;
  logic [NUM_SRC-1:0]         pend;

  irq_cfg_regs #(
    .NUM_SRC (NUM_SRC),
    .FIELD_W (FIELD_W),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (bus_wr_en_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .src_i        (src_level_i),
    .mask_o       (mask),
    .route_flat_o (route_flat),
    .rdata_o      (bus_rdata_o)
  );

  irq_line_router #(
    .NUM_SRC   (NUM_SRC),
    .NUM_LINES (NUM_LINES),
    .FIELD_W   (FIELD_W)
  ) u_router (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_i       (mask),
    .src_i        (src_level_i),
    .route_flat_i (route_flat),
    .line_o       (irq_line_o)
  );

  assign pend = mask & src_level_i;

  irq_lowest_finder #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_finder (
    .pend_i  (pend),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

  // a_r7_idx_pending: the reported source is itself pending
  a_r7_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> pend[pend_idx_o])
    else $error("R7 reported source is not pending");

  // a_r7_nothing_lower: no pending source below the reported one
  a_r7_nothing_lower: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> ((pend & ~({NUM_SRC{1'b1}} << pend_idx_o)) == '0))
    else $error("R7 a lower source is pending");

  // a_r7_empty: valid low only when nothing is pending
  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_valid_o |-> (pend == '0))
    else $error("R7 valid low while sources pending");

endmodule

// File: tb/routed_irq_ctrl_bench.sv
`timescale 1ns/1ps
module routed_irq_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_en;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [7:0]  irq_line;
  logic        pend_valid;
  logic [4:0]  pend_idx;

  routed_irq_ctrl u_routed_irq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_level_i  (src),
    .bus_wr_en_i  (wr_en),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .irq_line_o   (irq_line),
    .pend_valid_o (pend_valid),
    .pend_idx_o   (pend_idx)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state
  logic [31:0]       mask_m;
  logic [3:0][31:0]  route_m;
  logic [7:0]        exp_lines;
  logic [31:0]       lfsr;

  function automatic logic [7:0] model_lines(input logic [31:0] s, input logic [31:0] m,
                                             input logic [3:0][31:0] r);
    logic [7:0] res = '0;
    for (int i = 0; i < 32; i++) begin
      int f = int'(r[i / 8][(i % 8) * 4 +: 4]);
      if (m[i] && s[i] && f < 8) res[f] = 1'b1;
    end
    return res;
  endfunction

  function automatic int model_lowest(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One clock: model from pre-edge values, compare lines and dispatch outputs after
  task automatic tick();
    int lw;
    if (!rst_n) begin
      mask_m  = '0;
      route_m = '0;
    end
    exp_lines = model_lines(src, mask_m, route_m);
    if (wr_en && rst_n) begin
      case (addr)
        8'h00: mask_m = wdata;
        8'h08: route_m[0] = wdata;
        8'h0C: route_m[1] = wdata;
        8'h10: route_m[2] = wdata;
        8'h14: route_m[3] = wdata;
        default: ;
      endcase
    end
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) exp_lines = '0;
    chk(irq_line === exp_lines, "R5 lines per clock", {24'h0, irq_line}, {24'h0, exp_lines});
    lw = model_lowest(mask_m & src);
    if (rst_n) begin
      chk(pend_valid === (lw >= 0), "R7 valid per clock", {31'h0, pend_valid}, {31'h0, lw >= 0});
      if (lw >= 0)
        chk(pend_idx === 5'(lw), "R7 index per clock", {27'h0, pend_idx}, 32'(lw));
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1;
    addr  = a;
    wdata = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a;
    #1;
    chk(rdata === e, tag, rdata, e);
    tick();
  endtask

  task automatic regs_unchanged(input string tag);
    rd_chk(8'h00, mask_m, tag);
    rd_chk(8'h08, route_m[0], tag);
    rd_chk(8'h0C, route_m[1], tag);
    rd_chk(8'h10, route_m[2], tag);
    rd_chk(8'h14, route_m[3], tag);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1;
    wr_en = 1'b0;
    addr  = '0;
    wdata = '0;
    src   = '0;
    mask_m  = '0;
    route_m = '0;
    lfsr  = 32'h1ACE_B00C;
    #1 rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    src   = 32'hFFFF_FFFF;
    tick();

    // R1: reset state
    chk(irq_line === 8'h00, "R1 lines low after reset", {24'h0, irq_line}, 32'h0);
    rd_chk(8'h00, 32'h0, "R1 enable reset value");
    rd_chk(8'h08, 32'h0, "R1 steering0 reset value");
    rd_chk(8'h0C, 32'h0, "R1 steering1 reset value");
    rd_chk(8'h10, 32'h0, "R1 steering2 reset value");
    rd_chk(8'h14, 32'h0, "R1 steering3 reset value");
    src = '0;

    // R3: steering programming and readback
    wr(8'h08, 32'h7654_3210);
    wr(8'h0C, 32'h89AB_CDEF);
    wr(8'h10, 32'h0123_4567);
    wr(8'h14, 32'h5555_5555);
    rd_chk(8'h08, 32'h7654_3210, "R3 steering0 readback");
    rd_chk(8'h0C, 32'h89AB_CDEF, "R3 steering1 readback");
    rd_chk(8'h10, 32'h0123_4567, "R3 steering2 readback");
    rd_chk(8'h14, 32'h5555_5555, "R3 steering3 readback");

    // R2: enable register
    wr(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'hFFFF_FFFF, "R2 enable readback");

    // R5: walk one source across all positions
    for (int s = 0; s < 32; s++) begin
      src = 32'h1 << s;
      tick();
      tick();
    end

    // R5: registered latency of one clock
    src = '0;
    tick();
    src = 32'h0000_0008;
    #1 chk(irq_line === 8'h00, "R5 no change before edge", {24'h0, irq_line}, 32'h0);
    tick();
    chk(irq_line === 8'h08, "R5 line 3 after one edge", {24'h0, irq_line}, 32'h08);

    // R8: held level keeps the line, release drops it one clock later
    for (int i = 0; i < 10; i++) begin
      tick();
      chk(irq_line === 8'h08, "R8 line held while source high", {24'h0, irq_line}, 32'h08);
    end
    src = '0;
    tick();
    chk(irq_line === 8'h00, "R8 line falls after source low", {24'h0, irq_line}, 32'h0);

    // R5: several sources OR onto one line
    src = 32'hFF00_0000;
    tick();
    chk(irq_line === 8'h20, "R5 sources 24-31 on line 5", {24'h0, irq_line}, 32'h20);

    // R6: selectors 8..15 drive nothing
    src = 32'h0000_FF00;
    tick();
    tick();
    chk(irq_line === 8'h00, "R6 out-of-range selectors silent", {24'h0, irq_line}, 32'h0);

    // R7: lowest pending index
    src = 32'h8000_0000;
    #1 chk(pend_idx === 5'd31 && pend_valid, "R7 index 31", {27'h0, pend_idx}, 32'd31);
    tick();
    src = 32'h0001_0010;
    #1 chk(pend_idx === 5'd4 && pend_valid, "R7 index 4", {27'h0, pend_idx}, 32'd4);
    tick();
    wr(8'h00, 32'hFFFF_FFEF);
    #1 chk(pend_idx === 5'd16 && pend_valid, "R7 disabled source skipped", {27'h0, pend_idx}, 32'd16);
    tick();
    src = '0;
    #1 chk(pend_valid === 1'b0, "R7 none pending", {31'h0, pend_valid}, 32'h0);
    tick();

    // R2: enable gating
    wr(8'h00, 32'h0000_0000);
    src = 32'hFFFF_FFFF;
    tick();
    tick();
    chk(irq_line === 8'h00, "R2 all disabled gives no line", {24'h0, irq_line}, 32'h0);
    rd_chk(8'h18, 32'h0, "R4 pending view empty");
    wr(8'h00, 32'h0000_00F0);
    tick();
    chk(irq_line === 8'hF0, "R2 sources 4-7 on lines 4-7", {24'h0, irq_line}, 32'hF0);
    rd_chk(8'h18, 32'h0000_00F0, "R4 pending view");

    // R4: status view and ignored writes
    src = 32'hA5A5_0F0F;
    rd_chk(8'h04, 32'hA5A5_0F0F, "R4 status shows raw levels");
    wr(8'h04, 32'hDEAD_BEEF);
    rd_chk(8'h04, 32'hA5A5_0F0F, "R4 status after write");
    regs_unchanged("R4 write to status ignored");
    wr(8'h18, 32'h0000_0000);
    regs_unchanged("R4 write to pending view ignored");
    rd_chk(8'h18, 32'h0000_0000 | (32'h0000_00F0 & 32'hA5A5_0F0F), "R4 pending after write");

    // R9: unmapped offsets
    rd_chk(8'h1C, 32'h0, "R9 unmapped reads zero");
    rd_chk(8'h40, 32'h0, "R9 far unmapped reads zero");
    wr(8'h1C, 32'h1234_5678);
    wr(8'h02, 32'hFFFF_FFFF);
    regs_unchanged("R9 unmapped write ignored");

    // R5/R6/R7: pseudo-random traffic with reprogramming
    for (int c = 0; c < 400; c++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      src  = lfsr;
      if (c % 16 == 5) begin
        logic [7:0] a;
        case (lfsr[2:0])
          3'd0, 3'd1: a = 8'h00;
          3'd2:       a = 8'h08;
          3'd3:       a = 8'h0C;
          3'd4:       a = 8'h10;
          3'd5:       a = 8'h14;
          default:    a = 8'h04;
        endcase
        wr(a, {lfsr[15:0], lfsr[31:16]});
      end else begin
        tick();
      end
    end
    regs_unchanged("R3 registers after traffic");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule